// File: doc/BRIEF.md
# Packed Floating-Point Maximum Unit

This unit takes two 128-bit vector operands and returns, for each lane, the larger of the two values. A mode input picks the lane layout: two double-precision lanes, four single-precision lanes, or one double-precision lane in the low 64 bits with the upper 64 bits copied from operand A. The comparison is deliberately asymmetric. When both values are zeros, or when either value is any kind of NaN, the lane result is always operand B's value. No IEEE NaN propagation takes place. Instead, the unit raises status flags.

Each operation reports two flags: invalid-operation (any NaN among the active lanes) and denormal-operand (any subnormal among the active lanes). Each flag has a mask input. If a raised flag is unmasked, the unit asserts an exception request and returns operand A unchanged. The raised flags are also OR-ed into a sticky two-bit status word, which only an explicit clear input resets.

Operands enter through a valid/ready handshake and leave through a one-stage registered output with its own valid/ready pair. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer without losing data. While `out_valid` is high and `out_ready` is low, the result, its flags and the exception request hold still.

Top module: `fpmax_unit`

## Requirements
- R1: Mode 2'b00 (and the spare code 2'b11) treats each operand as two 64-bit double-precision lanes, bits 63:0 and 127:64, and returns the larger value of each lane pair independently.
- R2: Mode 2'b01 treats each operand as four 32-bit single-precision lanes at bits 32*i+31:32*i, and returns the larger value of each lane pair independently.
- R3: Mode 2'b10 compares only bits 63:0 as one double. Result bits 127:64 equal operand A bits 127:64, and the upper lane never raises a flag.
- R4: Ordering is sign-magnitude. Any value with sign 0 exceeds any value with sign 1. Among two sign-0 values the larger magnitude wins, and among two sign-1 values the smaller magnitude wins. When the values are equal, B is returned.
- R5: When both lane values are zeros, whatever their signs, the lane result is operand B's lane.
- R6: When either lane value is a NaN (exponent all ones, fraction nonzero, quiet or signalling), the lane result is operand B's lane, provided no unmasked exception occurs.
- R7: `res_flags` bit 0 (invalid) is set if any active lane of A or B is a NaN. `res_flags` bit 1 (denormal) is set if any active lane of A or B has a zero exponent and a nonzero fraction. Both flags are ORed across the active lanes.
- R8: If a raised flag has its mask input at 0, `exc_req` is 1 and `res` equals operand A in full. The flag is still reported in `res_flags` and in `status`.
- R9: `status` (bit 0 invalid, bit 1 denormal) is sticky. It ORs in the flags of every accepted operation and is cleared only by `clr_status`. If a clear and an accept happen in the same cycle, the status keeps the new operation's flags.
- R10: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and its result appears with `out_valid` 1 after that edge. `in_ready` equals `!out_valid || out_ready`, and while `out_valid && !out_ready` the outputs stay stable.
- R11: After reset, `out_valid` is 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and controls are valid |
| in_ready | output | 1 | Unit can accept an operation |
| op_a | input | 128 | First operand; also the pass-through source |
| op_b | input | 128 | Second operand; the preferred value on zeros and NaNs |
| mode | input | 2 | 00 packed double, 01 packed single, 10 scalar double, 11 as 00 |
| mask_inv | input | 1 | 1 masks the invalid-operation exception |
| mask_den | input | 1 | 1 masks the denormal-operand exception |
| clr_status | input | 1 | Clears the sticky status word |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| res | output | 128 | Lane-wise maximum, or op_a on an unmasked exception |
| res_flags | output | 2 | Flags of this result: bit 0 invalid, bit 1 denormal |
| exc_req | output | 1 | An unmasked flag was raised for this result |
| status | output | 2 | Sticky flags: bit 0 invalid, bit 1 denormal |

## Verification
Every result, its flags and its exception request become visible one clock after the accepting edge, and the sticky status updates on that same edge. The bench drives each operation on a falling edge, lets exactly one rising edge pass, and compares all outputs on the next falling edge against values its reference functions computed before the stimulus. In stall tests the bench holds the consumer off, confirms that `in_ready` drops and that the outputs stay frozen over several edges, and then expects the queued operation to appear one edge after the release.

// File: rtl/fpmax_pkg.sv
package fpmax_pkg;
  typedef enum logic [1:0] {
    LAYOUT_PD  = 2'b00,
    LAYOUT_PS  = 2'b01,
    LAYOUT_SD  = 2'b10,
    LAYOUT_ALT = 2'b11
  } layout_e;

  localparam int VEC_W    = 128;
  localparam int FLAG_W   = 2;
  localparam int FLG_INV  = 0;
  localparam int FLG_DEN  = 1;

  localparam int SP_EXP   = 8;
  localparam int SP_MAN   = 23;
  localparam int DP_EXP   = 11;
  localparam int DP_MAN   = 52;
endpackage

// File: rtl/fpmax_lane.sv
module fpmax_lane #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         any_nan,
  output logic         any_den
);
  logic             sa, sb;
  logic [W-2:0]     mag_a, mag_b;
  logic             a_nan, b_nan, a_den, b_den, a_zero, b_zero;
  logic             a_wins;

  always_comb begin
    sa     = a[W-1];
    sb     = b[W-1];
    mag_a  = a[W-2:0];
    mag_b  = b[W-2:0];
    a_nan  = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
    b_nan  = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
    a_den  = (~|a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
    b_den  = (~|b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
    a_zero = ~|mag_a;
    b_zero = ~|mag_b;
    any_nan = a_nan | b_nan;
    any_den = a_den | b_den;
    if (any_nan || (a_zero && b_zero))
      a_wins = 1'b0;
    else if (sa != sb)
      a_wins = !sa;
    else if (!sa)
      a_wins = mag_a > mag_b;
    else
      a_wins = mag_a < mag_b;
    y = a_wins ? a : b;
  end

  // R5: two zeros always yield B's sign
  always_comb begin
    if (a_zero && b_zero)
      assert_zero_pick_b_R5: assert (y[W-1] == sb);
  end
endmodule

// File: rtl/fpmax_datapath.sv
module fpmax_datapath
  import fpmax_pkg::*;
#(
  parameter int WIDTH = VEC_W,
  localparam int SP_W   = 1 + SP_EXP + SP_MAN,
  localparam int DP_W   = 1 + DP_EXP + DP_MAN,
  localparam int N_SP   = WIDTH / SP_W,
  localparam int N_DP   = WIDTH / DP_W
) (
  input  logic [WIDTH-1:0]  a,
  input  logic [WIDTH-1:0]  b,
  input  logic [1:0]        layout,
  input  logic              mask_inv,
  input  logic              mask_den,
  output logic [WIDTH-1:0]  y,
  output logic [FLAG_W-1:0] flags,
  output logic              exc
);
  logic [WIDTH-1:0] y_sp, y_dp;
  logic [N_SP-1:0]  nan_sp, den_sp;
  logic [N_DP-1:0]  nan_dp, den_dp;

  for (genvar i = 0; i < N_SP; i++) begin : g_sp
    fpmax_lane #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_lane (
      .a(a[i*SP_W +: SP_W]), .b(b[i*SP_W +: SP_W]),
      .y(y_sp[i*SP_W +: SP_W]), .any_nan(nan_sp[i]), .any_den(den_sp[i])
    );
  end

  for (genvar i = 0; i < N_DP; i++) begin : g_dp
    fpmax_lane #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_lane (
      .a(a[i*DP_W +: DP_W]), .b(b[i*DP_W +: DP_W]),
      .y(y_dp[i*DP_W +: DP_W]), .any_nan(nan_dp[i]), .any_den(den_dp[i])
    );
  end

  logic [WIDTH-1:0] y_sel;
  always_comb begin
    unique case (layout_e'(layout))
      LAYOUT_PS: begin
        y_sel          = y_sp;
        flags[FLG_INV] = |nan_sp;
        flags[FLG_DEN] = |den_sp;
      end
      LAYOUT_SD: begin
        y_sel            = a;
        y_sel[DP_W-1:0]  = y_dp[DP_W-1:0];
        flags[FLG_INV]   = nan_dp[0];
        flags[FLG_DEN]   = den_dp[0];
      end
      default: begin
        y_sel          = y_dp;
        flags[FLG_INV] = |nan_dp;
        flags[FLG_DEN] = |den_dp;
      end
    endcase
    exc = (flags[FLG_INV] && !mask_inv) || (flags[FLG_DEN] && !mask_den);
    y   = exc ? a : y_sel;
  end

  // R8: an unmasked exception implies a raised flag
  always_comb begin
    if (exc)
      assert_exc_has_flag_R8: assert (|flags);
  end
endmodule

// File: rtl/fpmax_unit.sv
module fpmax_unit
  import fpmax_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] op_a,
  input  logic [127:0] op_b,
  input  logic [1:0]   mode,
  input  logic         mask_inv,
  input  logic         mask_den,
  input  logic         clr_status,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] res,
  output logic [1:0]   res_flags,
  output logic         exc_req,
  output logic [1:0]   status
);
  logic [VEC_W-1:0]  y_c;
  logic [FLAG_W-1:0] flags_c;
  logic              exc_c;
  logic              accept;

  fpmax_datapath #(.WIDTH(VEC_W)) u_dp (
    .a(op_a), .b(op_b), .layout(mode),
    .mask_inv(mask_inv), .mask_den(mask_den),
    .y(y_c), .flags(flags_c), .exc(exc_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      res_flags <= '0;
      exc_req   <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        res       <= y_c;
        res_flags <= flags_c;
        exc_req   <= exc_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status <= '0;
    else
      status <= (clr_status ? '0 : status) | (accept ? flags_c : '0);
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res) && $stable(res_flags) && $stable(exc_req)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_status |=> ((status & $past(status)) == $past(status)));

  assert_exc_keeps_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc_c) |=> (exc_req && res == $past(op_a)));

  assert_scalar_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == 2'b10) |=> (res[127:64] == $past(op_a[127:64])));

  assert_result_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
endmodule

// File: tb/fpmax_unit_bench.sv
module fpmax_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [127:0] op_a = '0, op_b = '0;
  logic [1:0]   mode = 2'b00;
  logic         mask_inv = 1'b1, mask_den = 1'b1, clr_status = 1'b0;
  logic         out_valid, out_ready = 1'b1;
  logic [127:0] res;
  logic [1:0]   res_flags, status;
  logic         exc_req;

  int n_chk = 0, n_bad = 0;
  logic [1:0]   st_exp = 2'b00;

  always #5 clk = ~clk;

  fpmax_unit u_fpmax_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .mode(mode), .mask_inv(mask_inv),
    .mask_den(mask_den), .clr_status(clr_status), .out_valid(out_valid),
    .out_ready(out_ready), .res(res), .res_flags(res_flags),
    .exc_req(exc_req), .status(status)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // returns {nan, den, y}
  function automatic logic [65:0] ref_lane(logic [63:0] a, logic [63:0] b, bit sp);
    logic sa, sb, na, nb, da, db, za, zb, gt;
    logic [62:0] ma, mb;
    if (sp) begin
      sa = a[31]; sb = b[31]; ma = {32'b0, a[30:0]}; mb = {32'b0, b[30:0]};
      na = (&a[30:23]) && (|a[22:0]); nb = (&b[30:23]) && (|b[22:0]);
      da = (~|a[30:23]) && (|a[22:0]); db = (~|b[30:23]) && (|b[22:0]);
    end else begin
      sa = a[63]; sb = b[63]; ma = a[62:0]; mb = b[62:0];
      na = (&a[62:52]) && (|a[51:0]); nb = (&b[62:52]) && (|b[51:0]);
      da = (~|a[62:52]) && (|a[51:0]); db = (~|b[62:52]) && (|b[51:0]);
    end
    za = (ma == 0); zb = (mb == 0);
    if (na || nb || (za && zb)) gt = 1'b0;
    else if (sa != sb) gt = !sa;
    else if (!sa) gt = ma > mb;
    else gt = ma < mb;
    return {na | nb, da | db, gt ? a : b};
  endfunction

  // returns {exc, flags[1:0], y[127:0]}
  function automatic logic [130:0] ref_op(logic [127:0] a, logic [127:0] b,
                                         logic [1:0] md, logic mi, logic mdn);
    logic [127:0] y; logic inv, den, ex; logic [65:0] r;
    y = a; inv = 0; den = 0;
    if (md == 2'b01) begin
      for (int i = 0; i < 4; i++) begin
        r = ref_lane({32'b0, a[i*32 +: 32]}, {32'b0, b[i*32 +: 32]}, 1'b1);
        y[i*32 +: 32] = r[31:0]; inv |= r[65]; den |= r[64];
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (!(md == 2'b10 && i == 1)) begin
          r = ref_lane(a[i*64 +: 64], b[i*64 +: 64], 1'b0);
          y[i*64 +: 64] = r[63:0]; inv |= r[65]; den |= r[64];
        end
      end
    end
    ex = (inv && !mi) || (den && !mdn);
    if (ex) y = a;
    return {ex, den, inv, y};
  endfunction

  function automatic logic [63:0] rv(bit sp);
    logic [63:0] v; int k;
    k = $urandom_range(0, 9);
    v = {$urandom, $urandom};
    if (sp) begin
      v[63:32] = 32'b0;
      case (k)
        0: v[30:0] = '0;
        1: v[30:23] = 8'hff;
        2: v[30:23] = 8'h00;
        3: v[30:0] = {8'hff, 23'b0};
        default: ;
      endcase
    end else begin
      case (k)
        0: v[62:0] = '0;
        1: v[62:52] = 11'h7ff;
        2: v[62:52] = 11'h000;
        3: v[62:0] = {11'h7ff, 52'b0};
        default: ;
      endcase
    end
    return v;
  endfunction

  task automatic run_op(string req, logic [127:0] a, logic [127:0] b,
                        logic [1:0] md, logic mi, logic mdn);
    logic [130:0] e;
    e = ref_op(a, b, md, mi, mdn);
    @(negedge clk);
    op_a = a; op_b = b; mode = md; mask_inv = mi; mask_den = mdn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    st_exp |= e[129:128];
    check({req, " out_valid R10"}, {127'b0, out_valid}, 128'd1);
    check({req, " res"}, res, e[127:0]);
    check({req, " flags R7"}, {126'b0, res_flags}, {126'b0, e[129:128]});
    check({req, " exc R8"}, {127'b0, exc_req}, {127'b0, e[130]});
    check({req, " status R9"}, {126'b0, status}, {126'b0, st_exp});
  endtask

  localparam logic [63:0] DP_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] DP_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] DP_QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] DP_SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] DP_DEN  = 64'h0000_0000_0000_0005;
  localparam logic [63:0] DP_NZ   = 64'h8000_0000_0000_0000;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [130:0] e1, e2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 out_valid reset", {127'b0, out_valid}, 128'd0);
    check("R11 status reset", {126'b0, status}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 in_ready idle", {127'b0, in_ready}, 128'd1);

    run_op("R1 dp basic", {DP_ONE, DP_TWO}, {DP_TWO, DP_ONE}, 2'b00, 1, 1);
    run_op("R4 neg mags", {DP_ONE | DP_NZ, DP_TWO | DP_NZ}, {DP_TWO | DP_NZ, DP_ONE | DP_NZ}, 2'b00, 1, 1);
    run_op("R4 sign", {DP_ONE | DP_NZ, DP_ONE}, {DP_TWO, DP_TWO | DP_NZ}, 2'b11, 1, 1);
    run_op("R5 zeros", {64'd0, DP_NZ}, {DP_NZ, 64'd0}, 2'b00, 1, 1);
    run_op("R6 R7 nan", {DP_QNAN, DP_TWO}, {DP_ONE, DP_SNAN}, 2'b00, 1, 1);
    run_op("R7 den", {DP_DEN, DP_ONE}, {DP_ONE, DP_TWO}, 2'b00, 1, 1);
    run_op("R2 sp", {32'hBF80_0000, 32'h0000_0000, 32'h7FC0_0000, 32'h4000_0000},
                    {32'hC000_0000, 32'h8000_0000, 32'h3F80_0000, 32'h3F80_0000}, 2'b01, 1, 1);
    run_op("R3 scalar", {DP_QNAN, DP_ONE}, {DP_DEN, DP_TWO}, 2'b10, 0, 0);
    check("R3 no upper flag", {126'b0, res_flags}, 128'd0);
    run_op("R8 unmasked inv", {DP_ONE, DP_TWO}, {DP_SNAN, DP_ONE}, 2'b00, 0, 1);
    run_op("R8 unmasked den", {DP_ONE, DP_TWO}, {DP_DEN, DP_ONE}, 2'b01, 1, 0);

    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0; st_exp = 2'b00;
    check("R9 clear", {126'b0, status}, 128'd0);

    // stall / back-pressure
    out_ready = 1'b0;
    e1 = ref_op({DP_ONE, DP_ONE}, {DP_TWO, DP_TWO}, 2'b00, 1, 1);
    run_op("R10 stall first", {DP_ONE, DP_ONE}, {DP_TWO, DP_TWO}, 2'b00, 1, 1);
    e2 = ref_op({DP_QNAN, DP_TWO}, {DP_ONE, DP_ONE}, 2'b00, 1, 1);
    op_a = {DP_QNAN, DP_TWO}; op_b = {DP_ONE, DP_ONE}; in_valid = 1'b1;
    #1;
    check("R10 in_ready low", {127'b0, in_ready}, 128'd0);
    repeat (2) @(negedge clk);
    check("R10 held res", res, e1[127:0]);
    check("R10 held valid", {127'b0, out_valid}, 128'd1);
    check("R9 no accept while stalled", {126'b0, status}, {126'b0, st_exp});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; st_exp |= e2[129:128];
    check("R10 second after release", res, e2[127:0]);
    check("R9 second flags", {126'b0, status}, {126'b0, st_exp});
    @(negedge clk);
    check("R10 drained", {127'b0, out_valid}, 128'd0);

    // clear together with accept keeps new flags
    @(negedge clk);
    clr_status = 1'b1; op_a = {DP_DEN, DP_ONE}; op_b = {DP_ONE, DP_ONE};
    mode = 2'b00; mask_inv = 1; mask_den = 1; in_valid = 1'b1;
    @(negedge clk);
    clr_status = 1'b0; in_valid = 1'b0; st_exp = 2'b10;
    check("R9 clear+accept", {126'b0, status}, 128'd2);

    for (int n = 0; n < 400; n++) begin
      logic [127:0] a, b; logic [1:0] md; bit sp;
      md = 2'($urandom_range(0, 3));
      sp = (md == 2'b01);
      if (sp) begin
        for (int i = 0; i < 4; i++) begin
          logic [63:0] t;
          t = rv(1'b1); a[i*32 +: 32] = t[31:0];
          t = rv(1'b1); b[i*32 +: 32] = t[31:0];
          if ($urandom_range(0, 5) == 0) b[i*32 +: 32] = a[i*32 +: 32];
        end
      end else begin
        a = {rv(1'b0), rv(1'b0)}; b = {rv(1'b0), rv(1'b0)};
      end
      run_op("R1 R2 R3 R6 random", a, b, md, 1'($urandom), 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule